// File: doc/BRIEF.md
# Capture Timestamp Extender

This block widens the 16-bit values latched by a free-running capture counter into 32-bit timestamps. The low counter runs from 0 to 65535 and then returns to 0. Each return is reported to the block as a one-cycle wrap pulse, and the block keeps an upper word that counts those pulses. When a capture strobe arrives, the captured low half is joined with an upper word. The result is presented one cycle later on a registered output with a one-cycle valid pulse.

The hard case is a capture reported in the same cycle as a wrap. The wrap is always applied first, so the upper word has already advanced. However, a captured low half that sits high in its range (above a fixed threshold, 0xE000 by default) must have been latched just before the counter rolled over. That capture is paired with the previous upper word, which is the advanced word minus one. A small low half in the same situation is paired with the advanced word. This keeps timestamps increasing across the rollover. Edge detection and period arithmetic are handled by neighbouring logic.

Top module: `ts_extender`

## Requirements
- R1: After synchronous reset, `ts_vld_o` is 0, `ts_o` is 0 and the upper word is 0, so a capture with no wrap in the first cycle after reset yields upper half 0x0000.
- R2: A capture with no wrap in the same cycle produces `ts_o = {upper, low}`, where `upper` is the current upper word and `low` is `cap_low_i`. The upper word occupies bits 31:16 and the low half occupies bits 15:0.
- R3: Each cycle with `wrap_i` high increments the upper word by exactly one. Cycles without `wrap_i` leave it unchanged.
- R4: When a capture and a wrap occur in the same cycle and `cap_low_i` is at most the threshold (0xE000), the upper half of the timestamp is the already incremented upper word.
- R5: When a capture and a wrap occur in the same cycle and `cap_low_i` is above the threshold, the upper half of the timestamp is the incremented upper word minus one, which is the word before the wrap.
- R6: `ts_vld_o` is high for exactly the cycle after each cycle with `cap_vld_i` high, and it is low otherwise.
- R7: The upper word counts modulo 65536. A wrap at 0xFFFF takes it to 0x0000, and the minus-one case at upper word 0x0000 yields 0xFFFF.
- R8: The threshold comparison is strict. In a wrap cycle, a low half of exactly 0xE000 takes the incremented word, and 0xE001 takes the previous word.
- R9: In cycles without a capture, `ts_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrap_i | input | 1 | One-cycle pulse: low counter rolled over from 65535 to 0 |
| cap_vld_i | input | 1 | One-cycle pulse: a capture value is present on `cap_low_i` |
| cap_low_i | input | 16 | Captured low counter value |
| ts_vld_o | output | 1 | Registered pulse: `ts_o` holds a new timestamp |
| ts_o | output | 32 | Registered extended timestamp, upper word in bits 31:16 |

## Verification
The block is driven with five kinds of input pattern:
- Captures with no wrap, which show that the current upper word is joined unchanged.
- Runs of bare wraps followed by a capture, which show that every wrap counts exactly once.
- Wrap-plus-capture cycles with low halves near 0x0000 and near 0xFFFF. These separate the incremented word from the previous word, and each timestamp is also checked to be above the one before it, as a real rollover would produce.
- Low halves of exactly 0xE000 and 0xE001 on a wrap cycle, which pin down the strict comparison.
- A long run of wraps that carries the upper word through 0xFFFF to 0x0000, which exposes any loss of modulo behaviour, including the minus-one case at zero.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;

  // Which upper word a capture is paired with
  typedef enum logic [1:0] {
    SEL_CURRENT  = 2'd0,  // no wrap this cycle
    SEL_ADVANCED = 2'd1,  // wrap this cycle, capture taken after rollover
    SEL_PREVIOUS = 2'd2   // wrap this cycle, capture taken before rollover
  } upper_sel_e;

  localparam int unsigned DEF_LOW_W  = 16;
  localparam int unsigned DEF_HIGH_W = 16;

endpackage

// File: rtl/tsx_msw_counter.sv
module tsx_msw_counter #(
  parameter int unsigned HIGH_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_i,
  output logic [HIGH_W-1:0] msw_o,
  output logic [HIGH_W-1:0] msw_after_o
);

  logic [HIGH_W-1:0] msw_q;

  // The wrap of this cycle is applied before any capture of this cycle
  assign msw_after_o = wrap_i ? msw_q + HIGH_W'(1) : msw_q;
  assign msw_o       = msw_q;

  always_ff @(posedge clk) begin
    if (rst) msw_q <= '0;
    else     msw_q <= msw_after_o;
  end

  AST_MSW_STEP: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> msw_q == $past(msw_q) + HIGH_W'(1)); // R3
  AST_MSW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(msw_q)); // R3

endmodule

// File: rtl/tsx_race_resolver.sv
module tsx_race_resolver
  import ts_ext_pkg::*;
#(
  parameter int unsigned LOW_W  = 16,
  parameter int unsigned HIGH_W = 16,
  parameter logic [LOW_W-1:0] LATE_THRESH = 16'hE000
) (
  input  logic              wrap_i,
  input  logic [LOW_W-1:0]  low_i,
  input  logic [HIGH_W-1:0] msw_cur_i,
  input  logic [HIGH_W-1:0] msw_after_i,
  output logic [HIGH_W-1:0] upper_o
);

  upper_sel_e sel;

  always_comb begin
    if (!wrap_i)                  sel = SEL_CURRENT;
    else if (low_i > LATE_THRESH) sel = SEL_PREVIOUS;
    else                          sel = SEL_ADVANCED;
  end

  always_comb begin
    unique case (sel)
      SEL_ADVANCED: upper_o = msw_after_i;
      SEL_PREVIOUS: upper_o = msw_after_i - HIGH_W'(1);
      default:      upper_o = msw_cur_i;
    endcase
  end

endmodule

// File: rtl/tsx_out_reg.sv
module tsx_out_reg #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_vld_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            ts_vld_o,
  output logic [TS_W-1:0] ts_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_vld_o <= 1'b0;
      ts_o     <= '0;
    end else begin
      ts_vld_o <= cap_vld_i;
      if (cap_vld_i) ts_o <= ts_i;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cap_vld_i |=> ts_vld_o); // R6
  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cap_vld_i |=> !ts_vld_o); // R6
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap_vld_i |=> $stable(ts_o)); // R9

endmodule

// File: rtl/ts_extender.sv
module ts_extender #(
  parameter int unsigned LOW_W  = ts_ext_pkg::DEF_LOW_W,
  parameter int unsigned HIGH_W = ts_ext_pkg::DEF_HIGH_W,
  parameter logic [LOW_W-1:0] LATE_THRESH = 16'hE000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wrap_i,
  input  logic                    cap_vld_i,
  input  logic [LOW_W-1:0]        cap_low_i,
  output logic                    ts_vld_o,
  output logic [LOW_W+HIGH_W-1:0] ts_o
);

  localparam int unsigned TS_W = LOW_W + HIGH_W;

  logic [HIGH_W-1:0] msw_cur;
  logic [HIGH_W-1:0] msw_after;
  logic [HIGH_W-1:0] upper;

  tsx_msw_counter #(.HIGH_W(HIGH_W)) u_msw (
    .clk         (clk),
    .rst         (rst),
    .wrap_i      (wrap_i),
    .msw_o       (msw_cur),
    .msw_after_o (msw_after)
  );

  tsx_race_resolver #(
    .LOW_W       (LOW_W),
    .HIGH_W      (HIGH_W),
    .LATE_THRESH (LATE_THRESH)
  ) u_race (
    .wrap_i      (wrap_i),
    .low_i       (cap_low_i),
    .msw_cur_i   (msw_cur),
    .msw_after_i (msw_after),
    .upper_o     (upper)
  );

  tsx_out_reg #(.TS_W(TS_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .cap_vld_i (cap_vld_i),
    .ts_i      ({upper, cap_low_i}),
    .ts_vld_o  (ts_vld_o),
    .ts_o      (ts_o)
  );

  // After the edge, msw_cur is the upper word with this cycle's wrap applied
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
    cap_vld_i |=> ts_o[LOW_W-1:0] == $past(cap_low_i)); // R2
  AST_NO_WRAP_UPPER: assert property (@(posedge clk) disable iff (rst)
    (cap_vld_i && !wrap_i) |=> ts_o[TS_W-1:LOW_W] == msw_cur); // R2
  AST_EARLY_UPPER: assert property (@(posedge clk) disable iff (rst)
    (cap_vld_i && wrap_i && cap_low_i <= LATE_THRESH)
      |=> ts_o[TS_W-1:LOW_W] == msw_cur); // R4
  AST_LATE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (cap_vld_i && wrap_i && cap_low_i > LATE_THRESH)
      |=> ts_o[TS_W-1:LOW_W] == msw_cur - HIGH_W'(1)); // R5

endmodule

// File: tb/tb_ts_extender.sv
module tb_ts_extender;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TH = 16'hE000;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrap_i, cap_vld_i;
  logic [15:0] cap_low_i;
  logic        ts_vld_o;
  logic [31:0] ts_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] exp_msw;
  logic [31:0] exp_ts;
  logic [31:0] last_ts;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_extender dut (
    .clk(clk), .rst(rst), .wrap_i(wrap_i), .cap_vld_i(cap_vld_i),
    .cap_low_i(cap_low_i), .ts_vld_o(ts_vld_o), .ts_o(ts_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Drives one cycle from a falling edge, then checks at the next falling edge
  task automatic cyc(input bit w, input bit c, input logic [15:0] l, input string req);
    logic [15:0] up;
    wrap_i = w; cap_vld_i = c; cap_low_i = l;
    if (!w)          up = exp_msw;
    else if (l > TH) up = exp_msw;            // previous word
    else             up = exp_msw + 16'd1;    // advanced word
    if (c) exp_ts = {up, l};
    if (w) exp_msw = exp_msw + 16'd1;
    @(negedge clk);
    wrap_i = 0; cap_vld_i = 0;
    if (c) begin
      check(ts_vld_o === 1'b1, {req, " R6 valid"}, {31'd0, ts_vld_o}, 32'd1);
      check(ts_o === exp_ts, req, ts_o, exp_ts);
    end else begin
      check(ts_vld_o === 1'b0, "R6 no capture", {31'd0, ts_vld_o}, 32'd0);
      check(ts_o === exp_ts, "R9 hold", ts_o, exp_ts);
    end
  endtask

  task automatic t_reset;
    rst = 1; wrap_i = 0; cap_vld_i = 0; cap_low_i = 16'h1234;
    exp_msw = 0; exp_ts = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check(ts_vld_o === 1'b0, "R1 valid low", {31'd0, ts_vld_o}, 32'd0);
    check(ts_o === 32'd0, "R1 ts zero", ts_o, 32'd0);
    cyc(0, 1, 16'h0042, "R1 first capture");
  endtask

  task automatic t_plain;
    cyc(0, 1, 16'h0000, "R2 low 0");
    cyc(0, 0, 16'h5555, "R9");
    cyc(0, 1, 16'hFFFF, "R2 low max");
    cyc(0, 1, 16'h8000, "R2 back to back");
  endtask

  task automatic t_wraps;
    cyc(1, 0, 16'h0, "R3");
    cyc(1, 0, 16'h0, "R3");
    cyc(0, 0, 16'h0, "R3");
    cyc(1, 0, 16'h0, "R3");
    cyc(0, 1, 16'h1000, "R3 count of three");
    check(ts_o[31:16] === 16'd3, "R3 upper", {16'd0, ts_o[31:16]}, 32'd3);
  endtask

  task automatic t_race;
    cyc(1, 1, 16'h0003, "R4 small low on wrap");
    cyc(1, 1, 16'hFFFE, "R5 large low on wrap");
    cyc(1, 1, 16'hE000, "R8 at threshold");
    cyc(1, 1, 16'hE001, "R8 above threshold");
    cyc(0, 0, 16'h0, "R9");
  endtask

  task automatic t_monotonic;
    cyc(0, 1, 16'hFFF0, "R2 before rollover");
    last_ts = ts_o;
    cyc(1, 1, 16'hFFFC, "R5 late capture");
    check(ts_o > last_ts, "R5 monotonic", ts_o, last_ts);
    last_ts = ts_o;
    cyc(0, 0, 16'h0, "R9");
    cyc(1, 1, 16'h0002, "R4 early capture");
    check(ts_o > last_ts, "R4 monotonic", ts_o, last_ts);
    last_ts = ts_o;
    cyc(0, 1, 16'h0010, "R2 after rollover");
    check(ts_o > last_ts, "R2 monotonic", ts_o, last_ts);
  endtask

  task automatic t_modulo;
    while (exp_msw != 16'hFFFF) cyc(1, 0, 16'h0, "R3 run");
    cyc(0, 1, 16'h0100, "R7 top word");
    cyc(1, 1, 16'h0010, "R7 roll to zero");
    check(ts_o[31:16] === 16'h0000, "R7 zero", {16'd0, ts_o[31:16]}, 32'd0);
    while (exp_msw != 16'hFFFF) cyc(1, 0, 16'h0, "R3 run");
    cyc(1, 1, 16'hF800, "R7 previous word at rollover");
    check(ts_o[31:16] === 16'hFFFF, "R7 previous", {16'd0, ts_o[31:16]}, 32'h0000FFFF);
    cyc(0, 1, 16'h0001, "R7 word zero after rollover");
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_plain;
    t_wraps;
    t_race;
    t_monotonic;
    t_modulo;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule